// File: doc/BRIEF.md
# Translation Table Endianness Access Unit

This unit stands between the table walkers and queue engines of an I/O memory management unit and the memory port those engines use. Every implicit access it receives names the kind of data structure it touches through a 4-bit tag. From that tag, the unit picks one of two byte-order controls. One is a global bit. The other is a per-device-context bit that travels with the request. The unit then byte-reverses 64-bit read and write data when the chosen order is big-endian.

Before issuing anything to memory, the unit validates the request. It rejects three cases with a cause code and never touches memory for them: a device context whose byte order cannot be honoured because big-endian capability is absent, a big-endian message-signalled-interrupt write that is not permitted, and a tag it does not recognise. Memory is byte-invariant. The unit only reorders bytes inside a doubleword and never changes an address.

Top module: `tbl_endian_unit`

## Requirements
- R1: Tags 0 (command queue), 1 (fault queue), 2 (page-request queue), 3 (device directory), 4 (G-stage table) and 5 (interrupt remap table) use `glb_be` as their byte order. The encoding is 0 for little-endian and 1 for big-endian.
- R2: Tags 6 (process directory) and 7 (first-stage S/VS table) use `req_dev_be` as their byte order, with the same 0/1 encoding.
- R3: A big-endian read returns the byte at the lowest address in `rsp_data[63:56]`. A little-endian read returns that byte in `rsp_data[7:0]`. Memory lane k (`mem_rdata[8k+7:8k]`) holds the byte at address+k.
- R4: A big-endian write places `req_wdata[63:56]` at the lowest address, that is, on lane 0. A little-endian write places `req_wdata[7:0]` there.
- R5: When `cap_be` is 0 and `req_dev_be` differs from `glb_be` on tags 6, 7 or 8, the response has `rsp_err`=1 and `rsp_cause`=259, and no memory request is issued.
- R6: When `cap_be` is 1, `req_dev_be` selects the order of tags 6 and 7 whatever the value of `glb_be`.
- R7: For tag 8, an interrupt message write, address bit 2 selects big-endian when set and little-endian when clear. A write with bit 2 set is rejected with cause 260 and no memory request unless both `cap_be` and `req_dev_be` are 1. The misconfiguration check of R5 takes priority over this check.
- R8: Tags 9 to 15 produce `rsp_err`=1 and `rsp_cause`=300 with no memory request.
- R9: `req_ready` is high only while no access is in flight. A successful response has `rsp_err`=0 and `rsp_cause`=0, and a write response returns `rsp_data`=0. `mem_req_valid` and its address and data stay stable until `mem_req_ready`.
- R10: After reset, `req_ready`=1, and `rsp_valid` and `mem_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_be | input | 1 | Global byte-order control |
| cap_be | input | 1 | Big-endian capability |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Unit idle, request accepted |
| req_kind | input | 4 | Structure tag |
| req_write | input | 1 | 1 = write |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Write value in requester order |
| req_dev_be | input | 1 | Device-context byte order |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 64 | Read value in requester order |
| rsp_err | output | 1 | Request rejected |
| rsp_cause | output | 12 | Reject cause |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_write | output | 1 | Memory write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 64 | Memory write lanes |
| mem_rsp_valid | input | 1 | Memory response strobe |
| mem_rdata | input | 64 | Memory read lanes |

## Verification
Reads use a doubleword with distinct ascending byte values. Each tag is tried under both settings of the global bit and both settings of the device bit. This shows which control a tag follows and whether the bytes come back reversed or straight. Writes are checked byte by byte through a later little-endian read, which tells write reversal apart from read reversal. The capability, device bit and address bit 2 combinations for interrupt writes separate the misconfiguration cause from the disallowed-type cause. A count of memory handshakes confirms that rejected requests never reach memory.

// File: rtl/tbe_pkg.sv
package tbe_pkg;
  localparam int KIND_W  = 4;
  localparam int CAUSE_W = 12;

  localparam logic [KIND_W-1:0] K_CMDQ  = 4'd0;
  localparam logic [KIND_W-1:0] K_FLTQ  = 4'd1;
  localparam logic [KIND_W-1:0] K_PGRQ  = 4'd2;
  localparam logic [KIND_W-1:0] K_DDIR  = 4'd3;
  localparam logic [KIND_W-1:0] K_GSTG  = 4'd4;
  localparam logic [KIND_W-1:0] K_IRTBL = 4'd5;
  localparam logic [KIND_W-1:0] K_PDIR  = 4'd6;
  localparam logic [KIND_W-1:0] K_FSTG  = 4'd7;
  localparam logic [KIND_W-1:0] K_MSGWR = 4'd8;

  localparam logic [CAUSE_W-1:0] CAUSE_NONE    = 12'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_MISCFG  = 12'd259;
  localparam logic [CAUSE_W-1:0] CAUSE_TTYPE   = 12'd260;
  localparam logic [CAUSE_W-1:0] CAUSE_BADKIND = 12'd300;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } state_e;
endpackage

// File: rtl/tbe_policy.sv
module tbe_policy
  import tbe_pkg::*;
(
  input  logic [KIND_W-1:0]  kind,
  input  logic               glb_be,
  input  logic               dev_be,
  input  logic               cap_be,
  input  logic               addr_b2,
  output logic               use_be,
  output logic               err,
  output logic [CAUSE_W-1:0] cause
);
  logic ctx_bad;
  assign ctx_bad = !cap_be && (dev_be != glb_be);

  always_comb begin
    use_be = glb_be;
    err    = 1'b0;
    cause  = CAUSE_NONE;
    case (kind)
      K_CMDQ, K_FLTQ, K_PGRQ, K_DDIR, K_GSTG, K_IRTBL: use_be = glb_be;
      K_PDIR, K_FSTG: begin
        use_be = dev_be;
        if (ctx_bad) begin
          err   = 1'b1;
          cause = CAUSE_MISCFG;
        end
      end
      K_MSGWR: begin
        use_be = addr_b2;
        if (ctx_bad) begin
          err   = 1'b1;
          cause = CAUSE_MISCFG;
        end else if (addr_b2 && !(cap_be && dev_be)) begin
          err   = 1'b1;
          cause = CAUSE_TTYPE;
        end
      end
      default: begin
        err   = 1'b1;
        cause = CAUSE_BADKIND;
      end
    endcase
  end

  always_comb begin
    if (err) assert (cause != CAUSE_NONE); // R8
  end
endmodule

// File: rtl/tbe_swap.sv
module tbe_swap #(
  parameter int DATA_W = 64
) (
  input  logic              en,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int LANES = DATA_W / 8;
  logic [DATA_W-1:0] rev;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rev[8*g +: 8] = din[8*(LANES-1-g) +: 8];
  end

  assign dout = en ? rev : din;
endmodule

// File: rtl/tbl_endian_unit.sv
module tbl_endian_unit
  import tbe_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               glb_be,
  input  logic               cap_be,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [KIND_W-1:0]  req_kind,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic               req_dev_be,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_data,
  output logic               rsp_err,
  output logic [CAUSE_W-1:0] rsp_cause,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_write,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic               mem_rsp_valid,
  input  logic [DATA_W-1:0]  mem_rdata
);
  state_e state;

  logic               pol_be, pol_err;
  logic [CAUSE_W-1:0] pol_cause;
  logic [DATA_W-1:0]  wdata_sw, rdata_sw;

  logic               be_q, wr_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  wdata_q, rdata_q;
  logic               err_q;
  logic [CAUSE_W-1:0] cause_q;

  tbe_policy u_policy (
    .kind    (req_kind),
    .glb_be  (glb_be),
    .dev_be  (req_dev_be),
    .cap_be  (cap_be),
    .addr_b2 (req_addr[2]),
    .use_be  (pol_be),
    .err     (pol_err),
    .cause   (pol_cause)
  );

  tbe_swap #(.DATA_W(DATA_W)) u_wswap (
    .en   (pol_be),
    .din  (req_wdata),
    .dout (wdata_sw)
  );

  tbe_swap #(.DATA_W(DATA_W)) u_rswap (
    .en   (be_q),
    .din  (mem_rdata),
    .dout (rdata_sw)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      be_q    <= 1'b0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            be_q    <= pol_be;
            wr_q    <= req_write;
            addr_q  <= req_addr;
            wdata_q <= wdata_sw;
            rdata_q <= '0;
            err_q   <= pol_err;
            cause_q <= pol_cause;
            state   <= pol_err ? ST_RESP : ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (mem_req_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            rdata_q <= wr_q ? '0 : rdata_sw;
            state   <= ST_RESP;
          end
        end
        ST_RESP: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_ISSUE);
  assign mem_write     = wr_q;
  assign mem_addr      = addr_q;
  assign mem_wdata     = wdata_q;
  assign rsp_valid     = (state == ST_RESP);
  assign rsp_data      = rdata_q;
  assign rsp_err       = err_q;
  assign rsp_cause     = cause_q;

  AST_REJECT_NO_MEM: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && pol_err) |=> !mem_req_valid); // R5

  AST_OK_NO_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_err) |-> (rsp_cause == CAUSE_NONE)); // R9

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_addr) && $stable(mem_wdata))); // R9

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid || rsp_valid) |-> !req_ready); // R9
endmodule

// File: tb/tb_tbl_endian_unit.sv
module tb_tbl_endian_unit;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        glb_be = 0, cap_be = 0;
  logic        req_valid = 0, req_ready;
  logic [3:0]  req_kind = 0;
  logic        req_write = 0;
  logic [AW-1:0] req_addr = 0;
  logic [63:0] req_wdata = 0;
  logic        req_dev_be = 0;
  logic        rsp_valid, rsp_err;
  logic [63:0] rsp_data;
  logic [11:0] rsp_cause;
  logic        mem_req_valid, mem_write;
  logic        mem_req_ready = 1'b1;
  logic [AW-1:0] mem_addr;
  logic [63:0] mem_wdata;
  logic        mem_rsp_valid = 0;
  logic [63:0] mem_rdata = 0;

  tbl_endian_unit #(.ADDR_W(AW), .DATA_W(64)) dut (
    .clk, .rst, .glb_be, .cap_be, .req_valid, .req_ready, .req_kind,
    .req_write, .req_addr, .req_wdata, .req_dev_be, .rsp_valid, .rsp_data,
    .rsp_err, .rsp_cause, .mem_req_valid, .mem_req_ready, .mem_write,
    .mem_addr, .mem_wdata, .mem_rsp_valid, .mem_rdata
  );

  logic [7:0] mem [0:255];
  int mem_hits = 0;

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      mem_hits <= mem_hits + 1;
      mem_rsp_valid <= 1'b1;
      for (int i = 0; i < 8; i++) begin
        if (mem_write) mem[8'(mem_addr[7:0] + i)] <= mem_wdata[8*i +: 8];
        else mem_rdata[8*i +: 8] <= mem[8'(mem_addr[7:0] + i)];
      end
    end
  end

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [63:0] r_data;
  logic        r_err;
  logic [11:0] r_cause;
  int          r_hits;
  logic        r_busy_ready;

  task automatic access(input logic [3:0] kind, input logic wr, input logic [AW-1:0] a,
                        input logic [63:0] wd, input logic dev);
    int h0;
    bit got;
    h0 = mem_hits;
    @(negedge clk);
    req_kind = kind; req_write = wr; req_addr = a; req_wdata = wd; req_dev_be = dev;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    r_busy_ready = req_ready;
    got = 0;
    for (int i = 0; i < 20 && !got; i++) begin
      if (rsp_valid) begin
        got = 1;
        r_data = rsp_data; r_err = rsp_err; r_cause = rsp_cause;
      end else @(negedge clk);
    end
    if (!got) begin
      r_data = 'x; r_err = 'x; r_cause = 'x;
    end
    @(negedge clk);
    r_hits = mem_hits - h0;
  endtask

  localparam logic [63:0] LE_V = 64'h0807060504030201;
  localparam logic [63:0] BE_V = 64'h0102030405060708;

  task automatic t_reset;
    chk("R10 req_ready", {63'd0, req_ready}, 64'd1);
    chk("R10 rsp_valid", {63'd0, rsp_valid}, 64'd0);
    chk("R10 mem_req_valid", {63'd0, mem_req_valid}, 64'd0);
  endtask

  task automatic t_preload;
    glb_be = 0; cap_be = 1;
    access(4'd0, 1'b1, 32'h10, LE_V, 1'b0);
    chk("R9 write rsp_data", r_data, 64'd0);
    chk("R9 write cause", {52'd0, r_cause}, 64'd0);
    chk("R9 busy req_ready", {63'd0, r_busy_ready}, 64'd0);
  endtask

  task automatic t_global;
    cap_be = 1;
    for (int k = 0; k < 6; k++) begin
      glb_be = 1;
      access(4'(k), 1'b0, 32'h10, 64'd0, 1'b0);
      chk($sformatf("R1 R3 kind%0d BE", k), r_data, BE_V);
      glb_be = 0;
      access(4'(k), 1'b0, 32'h10, 64'd0, 1'b1);
      chk($sformatf("R1 R3 kind%0d LE", k), r_data, LE_V);
    end
  endtask

  task automatic t_device;
    cap_be = 1;
    for (int k = 6; k < 8; k++) begin
      glb_be = 0;
      access(4'(k), 1'b0, 32'h10, 64'd0, 1'b1);
      chk($sformatf("R2 R6 kind%0d dev BE", k), r_data, BE_V);
      chk("R6 no error", {63'd0, r_err}, 64'd0);
      glb_be = 1;
      access(4'(k), 1'b0, 32'h10, 64'd0, 1'b0);
      chk($sformatf("R2 R6 kind%0d dev LE", k), r_data, LE_V);
    end
  endtask

  task automatic t_write;
    cap_be = 1; glb_be = 1;
    access(4'd4, 1'b1, 32'h20, 64'h1122334455667788, 1'b0);
    glb_be = 0;
    access(4'd0, 1'b0, 32'h20, 64'd0, 1'b0);
    chk("R4 BE write lanes", r_data, 64'h8877665544332211);
    access(4'd1, 1'b1, 32'h28, 64'h1122334455667788, 1'b0);
    access(4'd1, 1'b0, 32'h28, 64'd0, 1'b0);
    chk("R4 LE write lanes", r_data, 64'h1122334455667788);
  endtask

  task automatic t_miscfg;
    cap_be = 0; glb_be = 0;
    access(4'd7, 1'b0, 32'h10, 64'd0, 1'b1);
    chk("R5 err", {63'd0, r_err}, 64'd1);
    chk("R5 cause", {52'd0, r_cause}, 64'd259);
    chk("R5 no mem", 64'(r_hits), 64'd0);
    glb_be = 1;
    access(4'd6, 1'b0, 32'h10, 64'd0, 1'b0);
    chk("R5 pdir cause", {52'd0, r_cause}, 64'd259);
    access(4'd6, 1'b0, 32'h10, 64'd0, 1'b1);
    chk("R5 matching ok", r_data, BE_V);
  endtask

  task automatic t_msi;
    cap_be = 1; glb_be = 0;
    access(4'd8, 1'b1, 32'h44, 64'h00000000AABBCCDD, 1'b1);
    chk("R7 BE msi accepted", {63'd0, r_err}, 64'd0);
    access(4'd0, 1'b0, 32'h44, 64'd0, 1'b0);
    chk("R7 BE msi lanes", r_data, 64'hDDCCBBAA00000000);
    access(4'd8, 1'b1, 32'h44, 64'd0, 1'b0);
    chk("R7 dev off cause", {52'd0, r_cause}, 64'd260);
    chk("R7 no mem", 64'(r_hits), 64'd0);
    cap_be = 0;
    access(4'd8, 1'b1, 32'h44, 64'd0, 1'b0);
    chk("R7 no cap cause", {52'd0, r_cause}, 64'd260);
    access(4'd8, 1'b1, 32'h44, 64'd0, 1'b1);
    chk("R7 miscfg priority", {52'd0, r_cause}, 64'd259);
    access(4'd8, 1'b1, 32'h40, 64'h1122334455667788, 1'b0);
    chk("R7 LE msi ok", {63'd0, r_err}, 64'd0);
    access(4'd0, 1'b0, 32'h40, 64'd0, 1'b0);
    chk("R7 LE msi lanes", r_data, 64'h1122334455667788);
  endtask

  task automatic t_badkind;
    cap_be = 1; glb_be = 0;
    access(4'd9, 1'b0, 32'h10, 64'd0, 1'b0);
    chk("R8 kind9 cause", {52'd0, r_cause}, 64'd300);
    chk("R8 kind9 no mem", 64'(r_hits), 64'd0);
    access(4'd15, 1'b1, 32'h10, 64'd0, 1'b0);
    chk("R8 kind15 err", {63'd0, r_err}, 64'd1);
    chk("R8 kind15 cause", {52'd0, r_cause}, 64'd300);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_preload();
    t_global();
    t_device();
    t_write();
    t_miscfg();
    t_msi();
    t_badkind();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule